// File: doc/BRIEF.md
# Packed Decimal Adder

This block adds two packed decimal numbers of four digits each. Every digit takes four bits, holds a value from 0 to 9, and the least significant digit sits in bits 3:0. The block also takes a carry-in and gives a decimal carry-out. It is purely combinational: the outputs follow the inputs with no clock and no state.

Each digit stage adds its two digits and the carry from the stage below as plain binary numbers. If that binary result lies outside the decimal range, the stage adds six, which brings the digit back into 0 to 9 and raises a carry into the next stage. The carry from the top digit is the carry-out of the whole adder.

Operands must be valid decimal, meaning every nibble is 0 to 9. The result for any other nibble value is not defined.

Top module: `bcd_adder`

## Requirements
- R1: Output digit i equals (a_i + b_i + c_i) mod 10. Here a_i and b_i are the operand nibbles at bits 4i+3:4i, and c_i is the carry into digit i. The carry into digit 0 is carryIn.
- R2: When a_i + b_i + c_i is 9 or less, the output digit equals that sum and no carry goes to the next digit.
- R3: When a_i + b_i + c_i is between 10 and 15, the output digit is the sum minus 10 and the next digit receives a carry of 1.
- R4: When a_i + b_i + c_i is 16 or more, the output digit is the sum minus 10 and the next digit receives a carry of 1. For example, 9 + 9 gives digit 8 and carry 1, never 12.
- R5: The carry produced by digit i is the carry into digit i+1, so a carry can pass through every digit. For example, 0999 + 0001 gives 1000.
- R6: carryOut is the carry produced by the top digit. 9999 + 9999 with carryIn 1 gives 9999 with carryOut 1.
- R7: For valid operands, {carryOut, sumOut} read as decimal equals A + B + carryIn. carryOut is 1 exactly when that total is 10000 or more.
- R8: For valid operands, every output nibble is in the range 0 to 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addA | input | 16 | First operand, four packed decimal digits |
| addB | input | 16 | Second operand, four packed decimal digits |
| carryIn | input | 1 | Carry into the least significant digit |
| sumOut | output | 16 | Packed decimal sum |
| carryOut | output | 1 | Decimal carry out of the top digit |

## Verification
Whenever the operands are valid, the assertions check three things every time the inputs change:
- each output digit is in range and matches the modulo-10 sum of its inputs and incoming carry;
- each internal carry is set exactly when that digit's sum reaches ten;
- the top carry is the one that appears on carryOut.

The bench's scenarios are what show that a long carry passes all the way through the chain, and that the corner cases (9 + 9, and all nines with carryIn set) give the right values. The bench also compares the whole four-digit result against a decimal model for many random operands.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;
  localparam int DIGIT_BITS = 4;
  localparam int RAW_BITS   = DIGIT_BITS + 1;
  localparam int DEC_LIMIT  = 9;
  localparam logic [DIGIT_BITS-1:0] FIX_VALUE = DIGIT_BITS'(6);

  // Strobes sent from a digit's control to its datapath
  typedef struct packed {
    logic addSix;   // apply decimal correction
    logic carryUp;  // decimal carry into the next digit
  } digitStrobe_t;
endpackage

// File: rtl/bcd_digit_ctl.sv
module bcd_digit_ctl
  import bcd_adder_pkg::*;
(
  input  logic [RAW_BITS-1:0] rawSum,
  output digitStrobe_t        strobe
);
  logic overRange;
  logic binCarry;

  always_comb begin
    binCarry       = rawSum[DIGIT_BITS];
    // 10..15: top bit set together with either middle bit
    overRange      = rawSum[DIGIT_BITS-1] & (rawSum[DIGIT_BITS-2] | rawSum[DIGIT_BITS-3]);
    strobe.addSix  = binCarry | overRange;
    strobe.carryUp = binCarry | overRange;
  end
endmodule

// File: rtl/bcd_digit_path.sv
module bcd_digit_path
  import bcd_adder_pkg::*;
(
  input  logic [DIGIT_BITS-1:0] digA,
  input  logic [DIGIT_BITS-1:0] digB,
  input  logic                  digCarry,
  input  digitStrobe_t          strobe,
  output logic [RAW_BITS-1:0]   rawSum,
  output logic [DIGIT_BITS-1:0] digitOut
);
  always_comb begin
    rawSum   = {1'b0, digA} + {1'b0, digB} + {{DIGIT_BITS{1'b0}}, digCarry};
    digitOut = strobe.addSix ? (rawSum[DIGIT_BITS-1:0] + FIX_VALUE)
                             : rawSum[DIGIT_BITS-1:0];
  end
endmodule

// File: rtl/bcd_adder.sv
module bcd_adder
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_BITS
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [DIGITS:0] digitCarry;

  assign digitCarry[0] = carryIn;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    logic [RAW_BITS-1:0] raw;
    digitStrobe_t        strb;

    bcd_digit_path u_path (
      .digA     (addA[d*DIGIT_BITS +: DIGIT_BITS]),
      .digB     (addB[d*DIGIT_BITS +: DIGIT_BITS]),
      .digCarry (digitCarry[d]),
      .strobe   (strb),
      .rawSum   (raw),
      .digitOut (sumOut[d*DIGIT_BITS +: DIGIT_BITS])
    );

    bcd_digit_ctl u_ctl (
      .rawSum (raw),
      .strobe (strb)
    );

    assign digitCarry[d+1] = strb.carryUp;
  end

  assign carryOut = digitCarry[DIGITS];
endmodule

// File: rtl/bcd_adder_checker.sv
module bcd_adder_checker
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int WIDTH = DIGITS * DIGIT_BITS
) (
  input logic [WIDTH-1:0] addA,
  input logic [WIDTH-1:0] addB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sumOut,
  input logic             carryOut,
  input logic [DIGITS:0]  digitCarry
);
  always_comb begin
    for (int d = 0; d < DIGITS; d++) begin
      automatic int da = int'(addA[d*DIGIT_BITS +: DIGIT_BITS]);
      automatic int db = int'(addB[d*DIGIT_BITS +: DIGIT_BITS]);
      automatic int dc = int'(digitCarry[d]);
      automatic int ds = int'(sumOut[d*DIGIT_BITS +: DIGIT_BITS]);
      if (da <= DEC_LIMIT && db <= DEC_LIMIT) begin
        AST_DIGIT_RANGE: assert (ds <= DEC_LIMIT);                       // R8
        AST_DIGIT_MOD:   assert (ds == (da + db + dc) % 10);             // R1
        AST_CARRY_RULE:  assert (digitCarry[d+1] == ((da + db + dc) >= 10)); // R3
      end
    end
    AST_CHAIN_START: assert (digitCarry[0] == carryIn);                  // R5
    AST_TOP_CARRY:   assert (carryOut == digitCarry[DIGITS]);            // R6
  end
endmodule

bind bcd_adder bcd_adder_checker #(.DIGITS(DIGITS)) u_chk (
  .addA       (addA),
  .addB       (addB),
  .carryIn    (carryIn),
  .sumOut     (sumOut),
  .carryOut   (carryOut),
  .digitCarry (digitCarry)
);

// File: tb/bcd_adder_test.sv
module bcd_adder_test;
  localparam int DIGITS = 4;
  localparam int WIDTH  = DIGITS * 4;
  localparam int LIMIT  = 10000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIDTH-1:0] addA = '0, addB = '0;
  logic carryIn = 1'b0;
  logic [WIDTH-1:0] sumOut;
  logic carryOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int expSum[$];
  int expCarry[$];
  string expTag[$];

  always #10 clk = ~clk;

  bcd_adder #(.DIGITS(DIGITS)) uut (
    .addA(addA), .addB(addB), .carryIn(carryIn),
    .sumOut(sumOut), .carryOut(carryOut)
  );

  function automatic int toInt(logic [WIDTH-1:0] v);
    int r = 0;
    for (int d = DIGITS - 1; d >= 0; d--) r = r * 10 + int'(v[d*4 +: 4]);
    return r;
  endfunction

  function automatic logic [WIDTH-1:0] toBcd(int n);
    logic [WIDTH-1:0] r = '0;
    for (int d = 0; d < DIGITS; d++) begin
      r[d*4 +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  task automatic apply(input int a, input int b, input bit ci, input string tag);
    int total;
    @(posedge clk);
    addA    <= toBcd(a);
    addB    <= toBcd(b);
    carryIn <= ci;
    total = a + b + int'(ci);
    expSum.push_back(total % LIMIT);
    expCarry.push_back(int'(total >= LIMIT));
    expTag.push_back(tag);
    @(negedge clk);
    begin
      int es = expSum.pop_front();
      int ec = expCarry.pop_front();
      string t = expTag.pop_front();
      checks++;
      if (sumOut !== toBcd(es) || int'(carryOut) != ec) begin
        errors++;
        $display("FAIL %s: a=%0d b=%0d ci=%0d got sum=%h cout=%0d exp sum=%h cout=%0d",
                 t, a, b, ci, sumOut, carryOut, toBcd(es), ec);
      end
      for (int d = 0; d < DIGITS; d++) begin
        checks++;
        if (sumOut[d*4 +: 4] > 4'd9) begin
          errors++;
          $display("FAIL R8: digit %0d got %0d exp <=9", d, sumOut[d*4 +: 4]);
        end
      end
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (sumOut !== '0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R2 reset/idle: got %h %0d exp 0000 0", sumOut, carryOut);
    end
    apply(0, 0, 0, "R2 zero");
    apply(5, 4, 0, "R2 sum nine");
    apply(4, 4, 1, "R2 with carry-in");
    apply(5, 5, 0, "R3 sum ten");
    apply(7, 8, 0, "R3 sum fifteen");
    apply(9, 9, 0, "R4 nine plus nine");
    apply(9, 8, 1, "R4 raw eighteen");
    apply(9, 9, 1, "R4 raw nineteen");
    apply(999, 1, 0, "R5 ripple three digits");
    apply(9999, 0, 1, "R5 ripple all digits");
    apply(9999, 9999, 1, "R6 all nines");
    apply(4500, 5500, 0, "R6 top carry");
    apply(1234, 4321, 0, "R1 no carries");
    apply(3838, 6262, 0, "R7 mixed");
    for (int i = 0; i < 300; i++)
      apply(int'($urandom % LIMIT), int'($urandom % LIMIT), bit'($urandom % 2), "R7 random");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule